// File: doc/BRIEF.md
# Sampled Word Recognizer and Trigger Selector

This block watches a stream of sampled logic-analyzer inputs and decides when an acquisition should trigger. On each cycle where the sample enable is high it compares an 18-bit observation against a programmable pattern. The observation is the 16-bit data word plus a probe qualifier bit and an external qualifier bit. Each bit of the pattern has a value bit and a care bit, so any bit may be required high, required low or ignored. The registered result of that comparison is driven out as a match signal, so other equipment can trigger from it.

A selector picks the acquisition trigger from one of four sources: the external trigger line, data channel 0, the word comparison, or a manual pushbutton strobe. The external, channel 0 and manual sources are edge sources, judged only at samples. The word source is a level source, judged on every sample. The unit must be armed before it can fire. It reports only the first trigger after arming, as a one-cycle pulse, and then disarms itself.

Top module: `wordrec_trig`

## Requirements
- R1: The observation has data[i] in bit i for i in 0..15, probe_qual in bit 16 and ext_qual in bit 17. An observation bit agrees when its pat_care bit is 0 or when it equals its pat_value bit. The word is recognized when all 18 bits agree.
- R2: match_out is high in the cycle after a clock edge that sampled with sample_en high and a recognized word. It is low after every other edge, including any edge with sample_en low.
- R3: src_sel picks the trigger source with this encoding: 0 = ext_trig, 1 = data[0], 2 = word recognizer, 3 = manual_trig. The sources that are not selected have no effect on trig_pulse.
- R4: An edge source causes a trigger event when it is high at a sample and was low at the previous sample. Its history is updated only on samples, so a level held high, or a low that appears only between samples, causes no new event.
- R5: For the word source, every sample with a recognized word is an event, whether or not the previous sample matched. The resulting trig_pulse falls in the same cycle as match_out.
- R6: trig_pulse is high for one cycle, the cycle after an event, and only if the unit was armed when the event was sampled. A fire disarms the unit, and any later event is ignored until the unit is re-armed.
- R7: A cycle with arm high leaves the unit armed from the next edge on. This holds even when that same edge fires a trigger. An event sampled in the same edge as an arm that finds the unit disarmed does not fire.
- R8: Reset (rst_n low) clears trig_pulse, match_out and the armed state, and sets the history of every edge source to low.
- R9: With pat_care all zero, every sample is recognized, whatever the values of data and the qualifiers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm | input | 1 | Arm request for the trigger |
| sample_en | input | 1 | Marks a cycle that carries a sample |
| data | input | 16 | Sampled data word |
| probe_qual | input | 1 | Probe qualifier bit |
| ext_qual | input | 1 | External qualifier bit |
| pat_value | input | 18 | Required value for each observation bit |
| pat_care | input | 18 | 1 = bit is compared, 0 = bit is ignored |
| ext_trig | input | 1 | External trigger line |
| manual_trig | input | 1 | Manual pushbutton strobe |
| src_sel | input | 2 | Trigger source select |
| trig_pulse | output | 1 | One-cycle acquisition trigger |
| match_out | output | 1 | Registered word-recognized output |

## Verification
Arming and firing can meet on the same clock edge. The bench provokes this by raising arm in the cycle that samples a rising edge on the external trigger. In one run the unit is already armed, and the bench expects a trigger pulse and a unit that stays armed, so the next edge fires again. In the other run the unit is disarmed, and the bench expects no pulse, with the next edge firing. In the same way, the match output and the trigger pulse are expected to rise in the same cycle when the word source is selected.

// File: rtl/wrt_pkg.sv
package wrt_pkg;

  typedef enum logic [1:0] {
    SRC_EXT    = 2'd0,
    SRC_CH0    = 2'd1,
    SRC_WORD   = 2'd2,
    SRC_MANUAL = 2'd3
  } trig_src_e;

  localparam int SRC_W  = 2;
  localparam int EDGE_N = 3;  // ext, channel 0, manual

  // One observation bit agrees with the pattern when it is ignored or equal.
  function automatic logic bit_agrees(input logic obs, input logic want,
                                      input logic care);
    return (!care) || (obs == want);
  endfunction

  // Rising edge between two consecutive samples.
  function automatic logic rose_between(input logic now_lvl, input logic prev_lvl);
    return now_lvl && !prev_lvl;
  endfunction

endpackage

// File: rtl/wrt_word_match.sv
module wrt_word_match #(
  parameter int W = 18
) (
  input  logic [W-1:0] obs,
  input  logic [W-1:0] value,
  input  logic [W-1:0] care,
  output logic         hit
);
  import wrt_pkg::*;

  logic [W-1:0] agree;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign agree[i] = bit_agrees(obs[i], value[i], care[i]);
  end

  assign hit = &agree;

endmodule

// File: rtl/wrt_edge_det.sv
module wrt_edge_det #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sample_en,
  input  logic [N-1:0] level,
  output logic [N-1:0] rise
);
  import wrt_pkg::*;

  for (genvar c = 0; c < N; c++) begin : g_ch
    logic prev_q;

    always_ff @(posedge clk) begin
      if (!rst_n)         prev_q <= 1'b0;
      else if (sample_en) prev_q <= level[c];
    end

    assign rise[c] = sample_en && rose_between(level[c], prev_q);
  end

endmodule

// File: rtl/wrt_src_mux.sv
module wrt_src_mux (
  input  logic [wrt_pkg::SRC_W-1:0] sel,
  input  logic                      sample_en,
  input  logic                      ext_rise,
  input  logic                      ch0_rise,
  input  logic                      word_hit,
  input  logic                      man_rise,
  output logic                      event_o
);
  import wrt_pkg::*;

  always_comb begin
    event_o = 1'b0;
    case (trig_src_e'(sel))
      SRC_EXT:    event_o = ext_rise;
      SRC_CH0:    event_o = ch0_rise;
      SRC_WORD:   event_o = sample_en && word_hit;
      SRC_MANUAL: event_o = man_rise;
      default:    event_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/wrt_arm_ctl.sv
module wrt_arm_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic event_i,
  output logic trig_pulse,
  output logic armed
);
  logic fire;

  assign fire = armed && event_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed      <= 1'b0;
      trig_pulse <= 1'b0;
    end else begin
      trig_pulse <= fire;
      armed      <= arm || (armed && !fire);
    end
  end

endmodule

// File: rtl/wordrec_trig.sv
module wordrec_trig #(
  parameter int DATA_W = 16,
  parameter int QUAL_W = 2,
  localparam int PAT_W = DATA_W + QUAL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic              sample_en,
  input  logic [DATA_W-1:0] data,
  input  logic              probe_qual,
  input  logic              ext_qual,
  input  logic [PAT_W-1:0]  pat_value,
  input  logic [PAT_W-1:0]  pat_care,
  input  logic              ext_trig,
  input  logic              manual_trig,
  input  logic [1:0]        src_sel,
  output logic              trig_pulse,
  output logic              match_out
);
  import wrt_pkg::*;

  // Named internal events, visible to the bound checker.
  logic [PAT_W-1:0]  obs_word;
  logic              word_hit;
  logic [EDGE_N-1:0] edge_lvl;
  logic [EDGE_N-1:0] edge_rise;
  logic              src_event;
  logic              armed_q;
  logic              match_q;

  assign obs_word = {ext_qual, probe_qual, data};
  assign edge_lvl = {manual_trig, data[0], ext_trig};

  wrt_word_match #(.W(PAT_W)) u_match (
    .obs   (obs_word),
    .value (pat_value),
    .care  (pat_care),
    .hit   (word_hit)
  );

  wrt_edge_det #(.N(EDGE_N)) u_edges (
    .clk       (clk),
    .rst_n     (rst_n),
    .sample_en (sample_en),
    .level     (edge_lvl),
    .rise      (edge_rise)
  );

  wrt_src_mux u_mux (
    .sel       (src_sel),
    .sample_en (sample_en),
    .ext_rise  (edge_rise[0]),
    .ch0_rise  (edge_rise[1]),
    .word_hit  (word_hit),
    .man_rise  (edge_rise[2]),
    .event_o   (src_event)
  );

  wrt_arm_ctl u_arm (
    .clk        (clk),
    .rst_n      (rst_n),
    .arm        (arm),
    .event_i    (src_event),
    .trig_pulse (trig_pulse),
    .armed      (armed_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) match_q <= 1'b0;
    else        match_q <= sample_en && word_hit;
  end

  assign match_out = match_q;

endmodule

// File: rtl/wrt_checker.sv
module wrt_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       arm,
  input logic       sample_en,
  input logic [1:0] src_sel,
  input logic       ext_trig,
  input logic       trig_pulse,
  input logic       match_out,
  input logic       armed,
  input logic       word_hit
);
  import wrt_pkg::*;

  // R2: match output only after a sampled cycle
  p_match_needs_sample_r2: assert property (@(posedge clk) disable iff (!rst_n)
    match_out |-> $past(sample_en));

  // R1: match output tracks the comparator result of the sample
  p_match_follows_hit_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sample_en) |-> (match_out == $past(word_hit)));

  // R6: firing requires the armed state
  p_fire_needs_arm_r6: assert property (@(posedge clk) disable iff (!rst_n)
    trig_pulse |-> $past(armed));

  // R6: no trigger without a sample
  p_no_sample_no_fire_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(sample_en) |-> !trig_pulse);

  // R7: after a fire the unit is armed only if arm was present
  p_fire_disarms_r7: assert property (@(posedge clk) disable iff (!rst_n)
    trig_pulse |-> (armed == $past(arm)));

  // R5: a word-source trigger coincides with the match output
  p_word_with_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_pulse && ($past(src_sel) == SRC_WORD)) |-> match_out);

  // R4: an external-source trigger needs the line high at the sample
  p_ext_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_pulse && ($past(src_sel) == SRC_EXT)) |-> $past(ext_trig));

endmodule

bind wordrec_trig wrt_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .arm        (arm),
  .sample_en  (sample_en),
  .src_sel    (src_sel),
  .ext_trig   (ext_trig),
  .trig_pulse (trig_pulse),
  .match_out  (match_out),
  .armed      (armed_q),
  .word_hit   (word_hit)
);

// File: tb/tb_wordrec_trig.sv
module tb_wordrec_trig;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        arm = 1'b0;
  logic        sample_en = 1'b0;
  logic [15:0] data = '0;
  logic        probe_qual = 1'b0;
  logic        ext_qual = 1'b0;
  logic [17:0] pat_value = '0;
  logic [17:0] pat_care = '0;
  logic        ext_trig = 1'b0;
  logic        manual_trig = 1'b0;
  logic [1:0]  src_sel = 2'd0;
  logic        trig_pulse;
  logic        match_out;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #4 clk = ~clk;  // 125 MHz

  wordrec_trig dut (
    .clk(clk), .rst_n(rst_n), .arm(arm), .sample_en(sample_en), .data(data),
    .probe_qual(probe_qual), .ext_qual(ext_qual), .pat_value(pat_value),
    .pat_care(pat_care), .ext_trig(ext_trig), .manual_trig(manual_trig),
    .src_sel(src_sel), .trig_pulse(trig_pulse), .match_out(match_out)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  // Called at a falling edge; drives one cycle, returns at the next falling
  // edge, where the outputs show the result of that cycle.
  task automatic step(input logic sen, input logic arm_i);
    sample_en = sen;
    arm       = arm_i;
    @(negedge clk);
    sample_en = 1'b0;
    arm       = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    chk("R8 trig after reset", trig_pulse, 1'b0);
    chk("R8 match after reset", match_out, 1'b0);
  endtask

  task automatic t_dont_care();
    pat_care = '0; src_sel = 2'd2;
    data = 16'h1234; probe_qual = 0; ext_qual = 1;
    step(1, 0);
    chk("R9 all ignored matches", match_out, 1'b1);
    chk("R6 disarmed no trig", trig_pulse, 1'b0);
    data = 16'hFFFF; probe_qual = 1; ext_qual = 0;
    step(1, 0);
    chk("R9 other word matches", match_out, 1'b1);
  endtask

  task automatic t_compare();
    pat_care  = '1;
    pat_value = {1'b1, 1'b0, 16'hA5C3};
    data = 16'hA5C3; probe_qual = 0; ext_qual = 1;
    step(1, 0);
    chk("R1 exact match", match_out, 1'b1);
    data = 16'hA5C3 ^ 16'h0080;
    step(1, 0);
    chk("R1 data bit 7 differs", match_out, 1'b0);
    data = 16'hA5C3; probe_qual = 1;
    step(1, 0);
    chk("R1 probe qual bit 16 differs", match_out, 1'b0);
    probe_qual = 0; ext_qual = 0;
    step(1, 0);
    chk("R1 ext qual bit 17 differs", match_out, 1'b0);
    ext_qual = 1; pat_care[7] = 1'b0; data = 16'hA5C3 ^ 16'h0080;
    step(1, 0);
    chk("R1 ignored bit 7", match_out, 1'b1);
    pat_care[7] = 1'b1; data = 16'hA5C3;
  endtask

  task automatic t_sample_gate();
    step(0, 0);
    chk("R2 no sample no match", match_out, 1'b0);
    step(1, 0);
    chk("R2 sample matches", match_out, 1'b1);
    step(0, 0);
    chk("R2 match lasts one cycle", match_out, 1'b0);
  endtask

  task automatic t_word_trig();
    src_sel = 2'd2;
    step(0, 1);
    step(1, 0);
    chk("R5 word trig", trig_pulse, 1'b1);
    chk("R5 match same cycle", match_out, 1'b1);
    step(1, 0);
    chk("R6 later match ignored", trig_pulse, 1'b0);
    step(0, 1);
    step(1, 0);
    chk("R5 held match fires after rearm", trig_pulse, 1'b1);
    step(0, 0);
    chk("R6 pulse one cycle", trig_pulse, 1'b0);
  endtask

  task automatic t_ext();
    src_sel = 2'd0; pat_care = '1; data = 16'h0000;
    ext_trig = 0; step(1, 0);
    step(0, 1);
    ext_trig = 1; step(1, 0);
    chk("R4 ext rising fires", trig_pulse, 1'b1);
    step(0, 1);
    step(1, 0);
    chk("R4 held high no fire", trig_pulse, 1'b0);
    ext_trig = 0; step(0, 0);
    ext_trig = 1; step(1, 0);
    chk("R4 low between samples unseen", trig_pulse, 1'b0);
    ext_trig = 0; step(1, 0);
    ext_trig = 1; step(1, 0);
    chk("R4 new edge fires", trig_pulse, 1'b1);
  endtask

  task automatic t_ch0();
    src_sel = 2'd1; ext_trig = 0; data = 16'h0000;
    step(1, 0);
    step(0, 1);
    ext_trig = 1; step(1, 0);
    chk("R3 ext ignored when ch0 selected", trig_pulse, 1'b0);
    data = 16'h0001; step(1, 0);
    chk("R3 ch0 rising fires", trig_pulse, 1'b1);
  endtask

  task automatic t_manual();
    src_sel = 2'd3; manual_trig = 0;
    step(1, 0);
    step(0, 1);
    manual_trig = 1; step(0, 0);
    chk("R3 manual not sampled", trig_pulse, 1'b0);
    step(1, 0);
    chk("R3 manual fires at sample", trig_pulse, 1'b1);
    manual_trig = 0;
  endtask

  task automatic t_arm_overlap();
    src_sel = 2'd0;
    ext_trig = 0; step(1, 0);
    step(0, 1);
    ext_trig = 1; step(1, 1);
    chk("R7 armed fire with arm", trig_pulse, 1'b1);
    ext_trig = 0; step(1, 0);
    ext_trig = 1; step(1, 0);
    chk("R7 still armed fires again", trig_pulse, 1'b1);
    ext_trig = 0; step(1, 0);
    ext_trig = 1; step(1, 1);
    chk("R7 disarmed arm same edge no fire", trig_pulse, 1'b0);
    ext_trig = 0; step(1, 0);
    ext_trig = 1; step(1, 0);
    chk("R7 armed from next edge", trig_pulse, 1'b1);
  endtask

  task automatic t_mid_reset();
    src_sel = 2'd0; ext_trig = 1;
    step(1, 0);
    step(0, 1);
    do_reset();
    step(1, 0);
    chk("R8 reset disarms", trig_pulse, 1'b0);
    do_reset();
    step(0, 1);
    step(1, 0);
    chk("R8 history cleared by reset", trig_pulse, 1'b1);
    ext_trig = 0;
  endtask

  initial begin
    @(negedge clk);
    do_reset();
    t_reset();
    t_dont_care();
    t_compare();
    t_sample_gate();
    t_word_trig();
    t_ext();
    t_ch0();
    t_manual();
    t_arm_overlap();
    t_mid_reset();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule